// File: doc/BRIEF.md
# Microcoded Control Sequencer for a Multi-Cycle 32-bit Datapath

This block steers a multi-cycle 32-bit load/store datapath from a small read-only microcode table. Each instruction is carried out as a short run of micro-words. Every micro-word sets the datapath control lines directly. It also carries its own sequencing fields. These fields choose the next micro-address: step forward, jump through an opcode map, go back to fetch, or go back to fetch only when a zero-flag test passes.

All instructions share two micro-words at addresses 0 and 1. Word 0 fetches the instruction and advances the program counter. Word 1 decodes it and precomputes the branch target. At the end of word 1 the 6-bit opcode is mapped to the first micro-address of that instruction's own routine. An opcode the map does not know sends control back to fetch.

To add an instruction, edit the table and the opcode map. The next-address hardware does not change. The datapath itself sits outside this block: the register file, ALU, memories and the IR/MDR/ALUout holding registers. It reads the control outputs in the same cycle they are driven.

Top module: `useq_ctrl`

## Requirements
- R1: The reset input is active low and synchronous. A clock edge that sees it low makes `uaddr` 0 (fetch). This holds even in the middle of an instruction.
- R2: Word 0 (fetch) drives `ir_we`=1, `src_a`=0 (PC), `src_b`=01 (constant 4), `alu_fun`=000 (add), `pc_src`=01 (ALU result), and nothing else. `ir_we` is 1 only in word 0. The next micro-address is always 1.
- R3: Word 1 (decode) drives `src_a`=0, `src_b`=11 (sign-extended immediate shifted left by 2), `alu_fun`=000, `pc_src`=00 (hold). It then jumps through the opcode map.
- R4: The opcode map is fixed. 0x00 (R-type) goes to 7. 0x23 (load word) goes to 2. 0x2B (store word) goes to 5. 0x04 (branch if equal) goes to 9. 0x05 (branch if not equal) goes to 14. 0x02 (jump) goes to 11. 0x08 (add immediate) goes to 12. Any other opcode goes to 0.
- R5: The load-word routine runs words 2, 3, 4, then returns to 0. Word 2 drives `src_a`=1 (rs), `src_b`=10 (sign-extended immediate), add. Word 3 drives `mem_rd`=1. Word 4 drives `reg_we`=10 (rt written from MDR).
- R6: The store-word routine runs words 5 and 6, then returns to 0. Word 5 is the same address step as word 2. Word 6 drives `mem_wr`=1. No word of this routine writes a register.
- R7: The R-type routine runs words 7 and 8, then returns to 0. Word 7 drives `src_a`=1, `src_b`=00 (rt), add. Word 8 drives `reg_we`=01 (rd written from ALUout).
- R8: The add-immediate routine runs words 12 and 13, then returns to 0. Word 12 drives `src_a`=1, `src_b`=10, add. Word 13 drives `reg_we`=11 (rt written from ALUout).
- R9: Branch-if-equal, word 9, drives `src_a`=1, `src_b`=00, `alu_fun`=001 (subtract). With `zero`=1 it drives `pc_src`=10 (ALUout register) and returns to 0. With `zero`=0 it drives `pc_src`=00 and steps to word 10, an idle word that returns to 0.
- R10: Branch-if-not-equal, word 14, drives the same operands and subtract as word 9, but the zero test is inverted. With `zero`=0 it drives `pc_src`=10 and returns to 0. With `zero`=1 it drives `pc_src`=00 and steps to idle word 15, then returns to 0.
- R11: The jump routine is word 11. It drives `pc_src`=11 (jump target) and returns to 0. `pc_src`=11 appears in no other word.
- R12: `mem_rd` and `mem_wr` are never 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| opcode | input | 6 | Opcode field of the instruction register |
| zero | input | 1 | ALU zero flag from the datapath |
| src_a | output | 1 | ALU A source: 0 PC, 1 register rs |
| src_b | output | 2 | ALU B source: 00 rt, 01 four, 10 immediate, 11 immediate<<2 |
| alu_fun | output | 3 | ALU function: 000 add, 001 subtract, 010 and, 011 or, 100 set-less-than |
| reg_we | output | 2 | Register write: 00 none, 01 rd<-ALUout, 10 rt<-MDR, 11 rt<-ALUout |
| mem_rd | output | 1 | Data memory read strobe |
| mem_wr | output | 1 | Data memory write strobe |
| pc_src | output | 2 | PC update: 00 hold, 01 ALU result, 10 ALUout register, 11 jump target |
| ir_we | output | 1 | Instruction register load |
| uaddr | output | 4 | Current micro-address |

## Verification
A conditional-branch word performs two actions in one cycle. It decides whether the program counter takes the branch target, and it decides whether the micro-sequence returns to fetch or falls through to an idle word. Both decisions depend on the same zero test. The bench runs each branch routine with `zero` set and cleared. In every cycle it compares `pc_src` and `uaddr` against a trace built from R9 and R10: a taken branch must show target selection together with a return to word 0, and a branch that is not taken must show a held PC together with a step to the idle word. Reset arriving partway through a load is also checked. Control must land at fetch on the next edge.

// File: rtl/useq_pkg.sv
// Package: shared micro-word layout and encodings for the microcoded
// control sequencer. Assumes a 16-word store addressed by UA_W bits.
package useq_pkg;

    localparam int UA_W = 4;
    localparam int OP_W = 6;

    // Sequencing codes carried in each micro-word
    localparam logic [1:0] NX_SEQ   = 2'b00;
    localparam logic [1:0] NX_DISP  = 2'b01;
    localparam logic [1:0] NX_FETCH = 2'b10;
    localparam logic [1:0] NX_COND  = 2'b11;

    // Zero-flag test polarity
    localparam logic CND_EQ = 1'b0;
    localparam logic CND_NE = 1'b1;

    // ALU A source
    localparam logic SA_PC = 1'b0;
    localparam logic SA_RS = 1'b1;

    // ALU B source
    localparam logic [1:0] SB_RT   = 2'b00;
    localparam logic [1:0] SB_FOUR = 2'b01;
    localparam logic [1:0] SB_IMM  = 2'b10;
    localparam logic [1:0] SB_IMM4 = 2'b11;

    // ALU function
    localparam logic [2:0] AF_ADD = 3'd0;
    localparam logic [2:0] AF_SUB = 3'd1;
    localparam logic [2:0] AF_AND = 3'd2;
    localparam logic [2:0] AF_OR  = 3'd3;
    localparam logic [2:0] AF_SLT = 3'd4;

    // Register write-back selection
    localparam logic [1:0] RW_NONE   = 2'b00;
    localparam logic [1:0] RW_RD_ALU = 2'b01;
    localparam logic [1:0] RW_RT_MDR = 2'b10;
    localparam logic [1:0] RW_RT_ALU = 2'b11;

    // Program counter update
    localparam logic [1:0] PS_HOLD = 2'b00;
    localparam logic [1:0] PS_ALU  = 2'b01;
    localparam logic [1:0] PS_AOUT = 2'b10;
    localparam logic [1:0] PS_JMP  = 2'b11;

    // Micro-addresses of routine entry points
    localparam logic [UA_W-1:0] UA_FETCH  = 4'd0;
    localparam logic [UA_W-1:0] UA_DECODE = 4'd1;
    localparam logic [UA_W-1:0] UA_LW     = 4'd2;
    localparam logic [UA_W-1:0] UA_SW     = 4'd5;
    localparam logic [UA_W-1:0] UA_RTYPE  = 4'd7;
    localparam logic [UA_W-1:0] UA_BEQ    = 4'd9;
    localparam logic [UA_W-1:0] UA_BEQ_NT = 4'd10;
    localparam logic [UA_W-1:0] UA_JMP    = 4'd11;
    localparam logic [UA_W-1:0] UA_ADDI   = 4'd12;
    localparam logic [UA_W-1:0] UA_BNE    = 4'd14;
    localparam logic [UA_W-1:0] UA_BNE_NT = 4'd15;

    // Opcodes recognised by the dispatch map
    localparam logic [OP_W-1:0] OP_RTYPE = 6'h00;
    localparam logic [OP_W-1:0] OP_JMP   = 6'h02;
    localparam logic [OP_W-1:0] OP_BEQ   = 6'h04;
    localparam logic [OP_W-1:0] OP_BNE   = 6'h05;
    localparam logic [OP_W-1:0] OP_ADDI  = 6'h08;
    localparam logic [OP_W-1:0] OP_LW    = 6'h23;
    localparam logic [OP_W-1:0] OP_SW    = 6'h2B;

    typedef struct packed {
        logic       src_a;
        logic [1:0] src_b;
        logic [2:0] alu_fun;
        logic [1:0] reg_we;
        logic       mem_rd;
        logic       mem_wr;
        logic [1:0] pc_src;
        logic       ir_we;
        logic       cond;
        logic [1:0] nxt;
    } uword_t;

    // Builds one micro-word from its fields
    function automatic uword_t mk_uw(
        input logic       sa,
        input logic [1:0] sb,
        input logic [2:0] af,
        input logic [1:0] rw,
        input logic       mr,
        input logic       mw,
        input logic [1:0] ps,
        input logic       ir,
        input logic       cd,
        input logic [1:0] nx
    );
        uword_t w;
        w.src_a   = sa;
        w.src_b   = sb;
        w.alu_fun = af;
        w.reg_we  = rw;
        w.mem_rd  = mr;
        w.mem_wr  = mw;
        w.pc_src  = ps;
        w.ir_we   = ir;
        w.cond    = cd;
        w.nxt     = nx;
        return w;
    endfunction

endpackage

// File: rtl/useq_store.sv
// Control store: constant table of micro-words, one per micro-address.
// Purely combinational; an address with no routine reads a word that
// does nothing and returns to fetch.
module useq_store
    import useq_pkg::*;
#(
    parameter int AW = UA_W
) (
    input  logic [AW-1:0] addr,
    output uword_t        word
);

    // Table look-up of the micro-word at addr
    always_comb begin
        case (addr)
            UA_FETCH:  word = mk_uw(SA_PC, SB_FOUR, AF_ADD, RW_NONE,   1'b0, 1'b0, PS_ALU,  1'b1, CND_EQ, NX_SEQ);
            UA_DECODE: word = mk_uw(SA_PC, SB_IMM4, AF_ADD, RW_NONE,   1'b0, 1'b0, PS_HOLD, 1'b0, CND_EQ, NX_DISP);
            4'd2:      word = mk_uw(SA_RS, SB_IMM,  AF_ADD, RW_NONE,   1'b0, 1'b0, PS_HOLD, 1'b0, CND_EQ, NX_SEQ);
            4'd3:      word = mk_uw(SA_PC, SB_RT,   AF_ADD, RW_NONE,   1'b1, 1'b0, PS_HOLD, 1'b0, CND_EQ, NX_SEQ);
            4'd4:      word = mk_uw(SA_PC, SB_RT,   AF_ADD, RW_RT_MDR, 1'b0, 1'b0, PS_HOLD, 1'b0, CND_EQ, NX_FETCH);
            4'd5:      word = mk_uw(SA_RS, SB_IMM,  AF_ADD, RW_NONE,   1'b0, 1'b0, PS_HOLD, 1'b0, CND_EQ, NX_SEQ);
            4'd6:      word = mk_uw(SA_PC, SB_RT,   AF_ADD, RW_NONE,   1'b0, 1'b1, PS_HOLD, 1'b0, CND_EQ, NX_FETCH);
            4'd7:      word = mk_uw(SA_RS, SB_RT,   AF_ADD, RW_NONE,   1'b0, 1'b0, PS_HOLD, 1'b0, CND_EQ, NX_SEQ);
            4'd8:      word = mk_uw(SA_PC, SB_RT,   AF_ADD, RW_RD_ALU, 1'b0, 1'b0, PS_HOLD, 1'b0, CND_EQ, NX_FETCH);
            4'd9:      word = mk_uw(SA_RS, SB_RT,   AF_SUB, RW_NONE,   1'b0, 1'b0, PS_AOUT, 1'b0, CND_EQ, NX_COND);
            4'd10:     word = mk_uw(SA_PC, SB_RT,   AF_ADD, RW_NONE,   1'b0, 1'b0, PS_HOLD, 1'b0, CND_EQ, NX_FETCH);
            4'd11:     word = mk_uw(SA_PC, SB_RT,   AF_ADD, RW_NONE,   1'b0, 1'b0, PS_JMP,  1'b0, CND_EQ, NX_FETCH);
            4'd12:     word = mk_uw(SA_RS, SB_IMM,  AF_ADD, RW_NONE,   1'b0, 1'b0, PS_HOLD, 1'b0, CND_EQ, NX_SEQ);
            4'd13:     word = mk_uw(SA_PC, SB_RT,   AF_ADD, RW_RT_ALU, 1'b0, 1'b0, PS_HOLD, 1'b0, CND_EQ, NX_FETCH);
            4'd14:     word = mk_uw(SA_RS, SB_RT,   AF_SUB, RW_NONE,   1'b0, 1'b0, PS_AOUT, 1'b0, CND_NE, NX_COND);
            4'd15:     word = mk_uw(SA_PC, SB_RT,   AF_ADD, RW_NONE,   1'b0, 1'b0, PS_HOLD, 1'b0, CND_EQ, NX_FETCH);
            default:   word = mk_uw(SA_PC, SB_RT,   AF_ADD, RW_NONE,   1'b0, 1'b0, PS_HOLD, 1'b0, CND_EQ, NX_FETCH);
        endcase
    end

    // No stored word strobes both memory directions (R12)
    always_comb begin
        p_store_rdwr_r12: assert (!(word.mem_rd && word.mem_wr));
    end

endmodule

// File: rtl/useq_dispatch.sv
// Opcode dispatch map: turns the 6-bit opcode into the entry address of
// its micro-routine. Unknown opcodes are sent back to fetch.
module useq_dispatch
    import useq_pkg::*;
#(
    parameter int OW = OP_W,
    parameter int AW = UA_W
) (
    input  logic [OW-1:0] opcode,
    output logic [AW-1:0] entry
);

    logic hit;

    // Map look-up with a hit flag for recognised opcodes
    always_comb begin
        hit = 1'b1;
        case (opcode)
            OP_RTYPE: entry = UA_RTYPE;
            OP_LW:    entry = UA_LW;
            OP_SW:    entry = UA_SW;
            OP_BEQ:   entry = UA_BEQ;
            OP_BNE:   entry = UA_BNE;
            OP_JMP:   entry = UA_JMP;
            OP_ADDI:  entry = UA_ADDI;
            default: begin
                hit   = 1'b0;
                entry = UA_FETCH;
            end
        endcase
    end

    // A recognised opcode never lands on the shared fetch/decode words (R4)
    always_comb begin
        if (hit) begin
            p_disp_entry_r4: assert (entry > UA_DECODE);
        end
    end

endmodule

// File: rtl/useq_next.sv
// Next-address logic: chooses the following micro-address from the NEXT
// code of the current word, the dispatch entry and the zero-flag test.
module useq_next
    import useq_pkg::*;
#(
    parameter int AW = UA_W
) (
    input  logic [AW-1:0] upc,
    input  logic [1:0]    nxt,
    input  logic          cond,
    input  logic          zero,
    input  logic [AW-1:0] disp_addr,
    output logic          cond_met,
    output logic [AW-1:0] upc_nxt
);

    logic [AW-1:0] upc_inc;

    // Zero-flag test under the word's polarity
    always_comb begin
        cond_met = (cond == CND_NE) ? !zero : zero;
        upc_inc  = AW'(upc + 1'b1);
    end

    // Selection of the next micro-address
    always_comb begin
        case (nxt)
            NX_SEQ:   upc_nxt = upc_inc;
            NX_DISP:  upc_nxt = disp_addr;
            NX_FETCH: upc_nxt = UA_FETCH;
            default:  upc_nxt = cond_met ? UA_FETCH : upc_inc;
        endcase
    end

endmodule

// File: rtl/useq_ctrl.sv
// Microcoded control sequencer top. Holds the micro-PC, reads the
// control store and drives the datapath control lines. Assumes the
// datapath samples the outputs in the cycle they are shown and that the
// opcode is stable from fetch through decode.
module useq_ctrl
    import useq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [5:0] opcode,
    input  logic       zero,
    output logic       src_a,
    output logic [1:0] src_b,
    output logic [2:0] alu_fun,
    output logic [1:0] reg_we,
    output logic       mem_rd,
    output logic       mem_wr,
    output logic [1:0] pc_src,
    output logic       ir_we,
    output logic [3:0] uaddr
);

    logic [UA_W-1:0] upc;
    logic [UA_W-1:0] upc_nxt;
    logic [UA_W-1:0] disp_addr;
    logic            cond_met;
    uword_t          uw;

    useq_store #(.AW(UA_W)) i_store (
        .addr (upc),
        .word (uw)
    );

    useq_dispatch #(.OW(OP_W), .AW(UA_W)) i_disp (
        .opcode (opcode),
        .entry  (disp_addr)
    );

    useq_next #(.AW(UA_W)) i_next (
        .upc       (upc),
        .nxt       (uw.nxt),
        .cond      (uw.cond),
        .zero      (zero),
        .disp_addr (disp_addr),
        .cond_met  (cond_met),
        .upc_nxt   (upc_nxt)
    );

    // Micro-PC register with synchronous active-low reset to fetch
    always_ff @(posedge clk) begin
        if (!rst_n) upc <= UA_FETCH;
        else        upc <= upc_nxt;
    end

    // Field fan-out; a failed branch test holds the PC
    always_comb begin
        src_a   = uw.src_a;
        src_b   = uw.src_b;
        alu_fun = uw.alu_fun;
        reg_we  = uw.reg_we;
        mem_rd  = uw.mem_rd;
        mem_wr  = uw.mem_wr;
        ir_we   = uw.ir_we;
        pc_src  = (uw.nxt == NX_COND && !cond_met) ? PS_HOLD : uw.pc_src;
        uaddr   = upc;
    end

    p_reset_fetch_r1: assert property (@(posedge clk)
        !rst_n |=> (uaddr == UA_FETCH));

    p_fetch_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == UA_FETCH) |=> (uaddr == UA_DECODE));

    p_irwe_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ir_we |-> (uaddr == UA_FETCH));

    p_sw_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == 4'd6) |=> (uaddr == UA_FETCH));

    p_beq_taken_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == UA_BEQ && zero) |=> (uaddr == UA_FETCH));

    p_beq_fall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == UA_BEQ && !zero) |=> (uaddr == UA_BEQ_NT));

    p_bne_taken_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (uaddr == UA_BNE && !zero) |=> (uaddr == UA_FETCH));

    p_jump_only_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_src == PS_JMP) |-> (uaddr == UA_JMP));

    p_rdwr_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_rd && mem_wr));

endmodule

// File: tb/test_useq_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: a driver pushes the expected per-cycle control
// vector of each routine; a monitor pops and compares at falling edges.
module test_useq_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] opcode = 6'h3F;
    logic       zero = 1'b0;
    logic       src_a;
    logic [1:0] src_b;
    logic [2:0] alu_fun;
    logic [1:0] reg_we;
    logic       mem_rd;
    logic       mem_wr;
    logic [1:0] pc_src;
    logic       ir_we;
    logic [3:0] uaddr;

    int n_run = 0;
    int n_fail = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        logic [3:0] ua;
        logic       sa;
        logic [1:0] sb;
        logic [2:0] af;
        logic [1:0] rw;
        logic       mr;
        logic       mw;
        logic [1:0] ps;
        logic       ir;
        string      tag;
    } exp_t;

    exp_t sb_q[$];

    always #4 clk = ~clk;

    useq_ctrl i_useq_ctrl (
        .clk (clk), .rst_n (rst_n), .opcode (opcode), .zero (zero),
        .src_a (src_a), .src_b (src_b), .alu_fun (alu_fun), .reg_we (reg_we),
        .mem_rd (mem_rd), .mem_wr (mem_wr), .pc_src (pc_src), .ir_we (ir_we),
        .uaddr (uaddr)
    );

    task automatic push(input logic [3:0] ua, input logic sa, input logic [1:0] sb,
                        input logic [2:0] af, input logic [1:0] rw, input logic mr,
                        input logic mw, input logic [1:0] ps, input logic ir,
                        input string tag);
        exp_t e;
        e.ua = ua; e.sa = sa; e.sb = sb; e.af = af; e.rw = rw;
        e.mr = mr; e.mw = mw; e.ps = ps; e.ir = ir; e.tag = tag;
        sb_q.push_back(e);
    endtask

    // Shared fetch and decode steps of every routine
    task automatic push_front_end();
        push(4'd0, 1'b0, 2'b01, 3'd0, 2'b00, 1'b0, 1'b0, 2'b01, 1'b1, "R2");
        push(4'd1, 1'b0, 2'b11, 3'd0, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, "R3");
    endtask

    // Issue one instruction: queue its trace, drive inputs, wait to drain
    task automatic run_instr(input logic [5:0] op, input logic z);
        opcode = op;
        zero   = z;
        wait (sb_q.size() == 0);
        @(posedge clk);
        #1;
    endtask

    // Monitor: compares the design against the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && sb_q.size() > 0) begin
            exp_t e;
            e = sb_q.pop_front();
            n_run++;
            if (uaddr !== e.ua || src_a !== e.sa || src_b !== e.sb ||
                alu_fun !== e.af || reg_we !== e.rw || mem_rd !== e.mr ||
                mem_wr !== e.mw || pc_src !== e.ps || ir_we !== e.ir) begin
                n_fail++;
                $display("FAIL %s: actual ua=%0d sa=%b sb=%b af=%0d rw=%b rd=%b wr=%b ps=%b ir=%b expected ua=%0d sa=%b sb=%b af=%0d rw=%b rd=%b wr=%b ps=%b ir=%b",
                         e.tag, uaddr, src_a, src_b, alu_fun, reg_we, mem_rd, mem_wr, pc_src, ir_we,
                         e.ua, e.sa, e.sb, e.af, e.rw, e.mr, e.mw, e.ps, e.ir);
            end
        end
    end

    task automatic check_ua(input logic [3:0] exp_ua, input logic exp_ir, input string tag);
        n_run++;
        if (uaddr !== exp_ua || ir_we !== exp_ir) begin
            n_fail++;
            $display("FAIL %s: actual ua=%0d ir_we=%b expected ua=%0d ir_we=%b",
                     tag, uaddr, ir_we, exp_ua, exp_ir);
        end
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failure
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !done) begin
            n_fail++;
            $display("FAIL watchdog: actual cycles=%0d expected below 20000", cyc);
            finish_run();
        end
    end

    initial begin
        // R1: reset state
        @(posedge clk);
        #1;
        check_ua(4'd0, 1'b1, "R1 reset");
        @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R5 load word
        push_front_end();
        push(4'd2, 1'b1, 2'b10, 3'd0, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, "R5");
        push(4'd3, 1'b0, 2'b00, 3'd0, 2'b00, 1'b1, 1'b0, 2'b00, 1'b0, "R5");
        push(4'd4, 1'b0, 2'b00, 3'd0, 2'b10, 1'b0, 1'b0, 2'b00, 1'b0, "R5");
        run_instr(6'h23, 1'b0);

        // R6 store word
        push_front_end();
        push(4'd5, 1'b1, 2'b10, 3'd0, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, "R6");
        push(4'd6, 1'b0, 2'b00, 3'd0, 2'b00, 1'b0, 1'b1, 2'b00, 1'b0, "R6");
        run_instr(6'h2B, 1'b1);

        // R7 R-type
        push_front_end();
        push(4'd7, 1'b1, 2'b00, 3'd0, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, "R7");
        push(4'd8, 1'b0, 2'b00, 3'd0, 2'b01, 1'b0, 1'b0, 2'b00, 1'b0, "R7");
        run_instr(6'h00, 1'b0);

        // R8 add immediate
        push_front_end();
        push(4'd12, 1'b1, 2'b10, 3'd0, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, "R8");
        push(4'd13, 1'b0, 2'b00, 3'd0, 2'b11, 1'b0, 1'b0, 2'b00, 1'b0, "R8");
        run_instr(6'h08, 1'b0);

        // R9 branch if equal, taken
        push_front_end();
        push(4'd9, 1'b1, 2'b00, 3'd1, 2'b00, 1'b0, 1'b0, 2'b10, 1'b0, "R9 taken");
        run_instr(6'h04, 1'b1);

        // R9 branch if equal, not taken
        push_front_end();
        push(4'd9,  1'b1, 2'b00, 3'd1, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, "R9 not taken");
        push(4'd10, 1'b0, 2'b00, 3'd0, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, "R9 idle");
        run_instr(6'h04, 1'b0);

        // R10 branch if not equal, taken
        push_front_end();
        push(4'd14, 1'b1, 2'b00, 3'd1, 2'b00, 1'b0, 1'b0, 2'b10, 1'b0, "R10 taken");
        run_instr(6'h05, 1'b0);

        // R10 branch if not equal, not taken
        push_front_end();
        push(4'd14, 1'b1, 2'b00, 3'd1, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, "R10 not taken");
        push(4'd15, 1'b0, 2'b00, 3'd0, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, "R10 idle");
        run_instr(6'h05, 1'b1);

        // R11 jump
        push_front_end();
        push(4'd11, 1'b0, 2'b00, 3'd0, 2'b00, 1'b0, 1'b0, 2'b11, 1'b0, "R11");
        run_instr(6'h02, 1'b0);

        // R4 unknown opcodes go straight back to fetch
        push_front_end();
        run_instr(6'h3F, 1'b0);
        push_front_end();
        run_instr(6'h11, 1'b1);
        // Back-to-back check that fetch follows: R4
        push_front_end();
        push(4'd7, 1'b1, 2'b00, 3'd0, 2'b00, 1'b0, 1'b0, 2'b00, 1'b0, "R4 after unknown");
        push(4'd8, 1'b0, 2'b00, 3'd0, 2'b01, 1'b0, 1'b0, 2'b00, 1'b0, "R4 after unknown");
        run_instr(6'h00, 1'b0);

        // R1: reset in the middle of a load routine
        opcode = 6'h23;
        @(posedge clk);
        #1;
        @(posedge clk);
        #1;
        check_ua(4'd2, 1'b0, "R1 mid-load position");
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check_ua(4'd0, 1'b1, "R1 mid-load reset");
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check_ua(4'd1, 1'b0, "R1 restart decode");

        finish_run();
    end

endmodule